// File: doc/BRIEF.md
# Symbol Timing Loop Filter

This block is the loop filter of a symbol-timing recovery loop. Once per symbol, a strobe arrives together with a signed timing phase-error sample. The filter turns that sample into a signed frequency-offset word, which steers an external timing oscillator. The error detector that produces the sample and the oscillator that consumes the word are separate blocks.

A two-bit mode input selects the loop order. In the off state the loop is cut and the output is zero. In first order the word is the proportional (lead) term alone, added to a lag accumulator that stays frozen. In second order the filter runs lead/lag: the integral (lag) accumulator gains Ki·err on every symbol, and the output is the lead term plus the updated accumulator. A select input picks one of two gain pairs, one for acquisition and one for tracking. A two-bit code sets how many of the most significant output bits are kept: 8, 16, 24 or 32.

All inputs are sampled only on the strobe cycle, so a change to mode, gains, width or error takes effect at the next symbol. The accumulator and the output saturate rather than wrap.

Top module: `symtim_loop_filter`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears the lag accumulator and drives freq_word to 0. freq_word is 0 on the first cycle after reset.
- R2: freq_word and the accumulator change only on the clock edge at which sym_stb is high. Every input is captured at that edge, and inputs that change between strobes have no effect until the next strobe.
- R3: On a strobe with loop_mode 0 (off), or with the reserved code 3, freq_word becomes 0 and the lag accumulator is cleared.
- R4: On a strobe with loop_mode 1 (first order), the accumulator keeps its value and freq_word = Kp·err + accumulator.
- R5: On a strobe with loop_mode 2 (second order), accumulator ← accumulator + Ki·err and freq_word = Kp·err + new accumulator.
- R6: trk_sel = 0 selects the gain pair kp_acq/ki_acq, and trk_sel = 1 selects kp_trk/ki_trk.
- R7: width_code keeps the top N bits of the 32-bit word and forces the remaining low bits to zero: 0 → N=8, 1 → N=16, 2 → N=24, 3 → N=32.
- R8: The lag accumulator (32-bit signed) saturates at +2^31−1 and −2^31 instead of wrapping.
- R9: The 32-bit output sum (lead plus accumulator) saturates at 32'h7FFFFFFF and 32'h80000000 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_stb | input | 1 | One-cycle strobe, once per symbol |
| loop_mode | input | 2 | 0 off, 1 first order, 2 second order, 3 treated as off |
| trk_sel | input | 1 | 0 acquisition gains, 1 tracking gains |
| width_code | input | 2 | Kept MSB count: 8, 16, 24, 32 |
| kp_acq | input | GAIN_W | Signed proportional gain, acquisition |
| ki_acq | input | GAIN_W | Signed integral gain, acquisition |
| kp_trk | input | GAIN_W | Signed proportional gain, tracking |
| ki_trk | input | GAIN_W | Signed integral gain, tracking |
| err_in | input | ERR_W | Signed timing phase error for this symbol |
| freq_word | output | 32 | Signed frequency-offset word |

## Verification
A short sequence of mixed-sign errors walks the filter through second order, first order, off and the reserved code. This sequence tells a running lag accumulator apart from a frozen one and from a cleared one, and shows which gain pair each trk_sel value selects. Negative sums sent through each width code show which bit positions the mask keeps. Long runs of maximum-magnitude errors push the accumulator to both limits, which separates saturation from wrap-around. One extra strobe with a large lead term tests output saturation on its own. Inputs that change between strobes, and a reset in the middle of operation, show that nothing moves except at a strobe and that reset really clears the state.

// File: rtl/symtim_pkg.sv
`timescale 1ns/1ps
package symtim_pkg;

  localparam int FW_W = 32;

  typedef enum logic [1:0] {
    LOOP_OFF    = 2'd0,
    LOOP_FIRST  = 2'd1,
    LOOP_SECOND = 2'd2,
    LOOP_RSVD   = 2'd3
  } loop_mode_e;

  // Proportional path is live in first and second order only.
  function automatic logic loop_active(input loop_mode_e m);
    return (m == LOOP_FIRST) || (m == LOOP_SECOND);
  endfunction

  // Integral path input is non-zero only in second order.
  function automatic logic lag_enabled(input loop_mode_e m);
    return m == LOOP_SECOND;
  endfunction

  // Keep 8/16/24/32 most significant bits of the word.
  function automatic logic [FW_W-1:0] width_mask(input logic [1:0] code);
    logic [FW_W-1:0] m;
    case (code)
      2'd0:    m = 32'hFF00_0000;
      2'd1:    m = 32'hFFFF_0000;
      2'd2:    m = 32'hFFFF_FF00;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/symtim_gain_select.sv
`timescale 1ns/1ps
module symtim_gain_select #(
  parameter int GAIN_W = 12
) (
  input  logic                     trk_sel,
  input  logic signed [GAIN_W-1:0] kp_acq,
  input  logic signed [GAIN_W-1:0] ki_acq,
  input  logic signed [GAIN_W-1:0] kp_trk,
  input  logic signed [GAIN_W-1:0] ki_trk,
  output logic signed [GAIN_W-1:0] kp,
  output logic signed [GAIN_W-1:0] ki
);
  always_comb begin
    if (trk_sel) begin
      kp = kp_trk;
      ki = ki_trk;
    end else begin
      kp = kp_acq;
      ki = ki_acq;
    end
  end
endmodule

// File: rtl/symtim_lag_accum.sv
`timescale 1ns/1ps
module symtim_lag_accum #(
  parameter int PROD_W = 24,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stb,
  input  logic                     clear,
  input  logic signed [PROD_W-1:0] lag_term,
  output logic signed [ACC_W-1:0]  acc_q,
  output logic signed [ACC_W-1:0]  acc_next
);
  localparam int S_W = ACC_W + 1;

  logic signed [S_W-1:0] acc_sum;
  logic                  ovf;

  always_comb begin
    acc_sum = {acc_q[ACC_W-1], acc_q}
            + {{(S_W-PROD_W){lag_term[PROD_W-1]}}, lag_term};
    ovf = acc_sum[S_W-1] != acc_sum[S_W-2];
    if (clear)
      acc_next = '0;
    else if (ovf)
      acc_next = acc_sum[S_W-1] ? {1'b1, {(ACC_W-1){1'b0}}}
                                : {1'b0, {(ACC_W-1){1'b1}}};
    else
      acc_next = acc_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else if (stb)
      acc_q <= acc_next;
  end
endmodule

// File: rtl/symtim_out_format.sv
`timescale 1ns/1ps
module symtim_out_format #(
  parameter int PROD_W = 24,
  parameter int ACC_W  = 32
) (
  input  logic signed [PROD_W-1:0]            lead,
  input  logic signed [ACC_W-1:0]             acc_val,
  input  logic [1:0]                          width_code,
  input  logic                                active,
  output logic [symtim_pkg::FW_W-1:0]         word
);
  import symtim_pkg::*;

  localparam int S_W = ACC_W + 1;
  localparam logic signed [S_W-1:0] OUT_MAX =
    {{(S_W-FW_W+1){1'b0}}, {(FW_W-1){1'b1}}};
  localparam logic signed [S_W-1:0] OUT_MIN = ~OUT_MAX;

  logic signed [S_W-1:0] sum;
  logic signed [S_W-1:0] sat;

  always_comb begin
    sum = {{(S_W-PROD_W){lead[PROD_W-1]}}, lead}
        + {acc_val[ACC_W-1], acc_val};
    if (sum > OUT_MAX)
      sat = OUT_MAX;
    else if (sum < OUT_MIN)
      sat = OUT_MIN;
    else
      sat = sum;
    word = active ? (sat[FW_W-1:0] & width_mask(width_code)) : '0;
  end
endmodule

// File: rtl/symtim_loop_filter.sv
`timescale 1ns/1ps
module symtim_loop_filter #(
  parameter int ERR_W  = 12,
  parameter int GAIN_W = 12,
  parameter int ACC_W  = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              sym_stb,
  input  logic [1:0]                        loop_mode,
  input  logic                              trk_sel,
  input  logic [1:0]                        width_code,
  input  logic signed [GAIN_W-1:0]          kp_acq,
  input  logic signed [GAIN_W-1:0]          ki_acq,
  input  logic signed [GAIN_W-1:0]          kp_trk,
  input  logic signed [GAIN_W-1:0]          ki_trk,
  input  logic signed [ERR_W-1:0]           err_in,
  output logic [symtim_pkg::FW_W-1:0]       freq_word
);
  import symtim_pkg::*;

  localparam int PROD_W = ERR_W + GAIN_W;

  loop_mode_e                mode;
  logic                      active;
  logic                      lag_en;
  logic signed [GAIN_W-1:0]  kp;
  logic signed [GAIN_W-1:0]  ki;
  logic signed [PROD_W-1:0]  lead_term;
  logic signed [PROD_W-1:0]  lag_prod;
  logic signed [PROD_W-1:0]  lag_term;
  logic signed [ACC_W-1:0]   acc_q;
  logic signed [ACC_W-1:0]   acc_next;
  logic [FW_W-1:0]           word_next;

  assign mode   = loop_mode_e'(loop_mode);
  assign active = loop_active(mode);
  assign lag_en = lag_enabled(mode);

  symtim_gain_select #(.GAIN_W(GAIN_W)) u_gain (
    .trk_sel (trk_sel),
    .kp_acq  (kp_acq),
    .ki_acq  (ki_acq),
    .kp_trk  (kp_trk),
    .ki_trk  (ki_trk),
    .kp      (kp),
    .ki      (ki)
  );

  assign lead_term = err_in * kp;
  assign lag_prod  = err_in * ki;
  assign lag_term  = lag_en ? lag_prod : '0;

  symtim_lag_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_lag (
    .clk      (clk),
    .rst      (rst),
    .stb      (sym_stb),
    .clear    (!active),
    .lag_term (lag_term),
    .acc_q    (acc_q),
    .acc_next (acc_next)
  );

  symtim_out_format #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_fmt (
    .lead       (lead_term),
    .acc_val    (acc_next),
    .width_code (width_code),
    .active     (active),
    .word       (word_next)
  );

  always_ff @(posedge clk) begin
    if (rst)
      freq_word <= '0;
    else if (sym_stb)
      freq_word <= word_next;
  end
endmodule

// File: rtl/symtim_loop_filter_chk.sv
`timescale 1ns/1ps
module symtim_loop_filter_chk #(
  parameter int PROD_W = 24,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sym_stb,
  input  logic [1:0]               loop_mode,
  input  logic [1:0]               width_code,
  input  logic [31:0]              freq_word,
  input  logic signed [ACC_W-1:0]  acc_q,
  input  logic signed [PROD_W-1:0] lag_term
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (freq_word == '0) && (acc_q == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sym_stb |=> $stable(freq_word) && $stable(acc_q)); // R2

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    sym_stb && (loop_mode == 2'd0 || loop_mode == 2'd3)
      |=> (freq_word == '0) && (acc_q == '0)); // R3

  AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    sym_stb && loop_mode == 2'd1 |=> $stable(acc_q)); // R4

  AST_WIDTH8_LOW: assert property (@(posedge clk) disable iff (rst)
    sym_stb && width_code == 2'd0 |=> freq_word[23:0] == 24'd0); // R7

  AST_ACC_NO_WRAP_POS: assert property (@(posedge clk) disable iff (rst)
    sym_stb && loop_mode == 2'd2 && acc_q >= 0 && lag_term >= 0
      |=> acc_q >= 0); // R8

  AST_ACC_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (rst)
    sym_stb && loop_mode == 2'd2 && acc_q < 0 && lag_term <= 0
      |=> acc_q < 0); // R8
endmodule

bind symtim_loop_filter symtim_loop_filter_chk #(
  .PROD_W (PROD_W),
  .ACC_W  (ACC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sym_stb    (sym_stb),
  .loop_mode  (loop_mode),
  .width_code (width_code),
  .freq_word  (freq_word),
  .acc_q      (acc_q),
  .lag_term   (lag_term)
);

// File: tb/tb_symtim_loop_filter.sv
`timescale 1ns/1ps
module tb_symtim_loop_filter;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sym_stb = 1'b0;
  logic [1:0]        loop_mode = 2'd0;
  logic              trk_sel = 1'b0;
  logic [1:0]        width_code = 2'd3;
  logic signed [11:0] kp_acq = 12'sd3;
  logic signed [11:0] ki_acq = 12'sd1;
  logic signed [11:0] kp_trk = 12'sd5;
  logic signed [11:0] ki_trk = 12'sd2;
  logic signed [11:0] err_in = '0;
  logic [31:0]       freq_word;

  int n_checks = 0;
  int n_err    = 0;

  always #2.5 clk = ~clk;

  symtim_loop_filter dut (
    .clk        (clk),
    .rst        (rst),
    .sym_stb    (sym_stb),
    .loop_mode  (loop_mode),
    .trk_sel    (trk_sel),
    .width_code (width_code),
    .kp_acq     (kp_acq),
    .ki_acq     (ki_acq),
    .kp_trk     (kp_trk),
    .ki_trk     (ki_trk),
    .err_in     (err_in),
    .freq_word  (freq_word)
  );

  // {tag[4], mode[2], trk[1], width[2], err[12], expected[32]}
  // Gains: acq Kp=3 Ki=1, trk Kp=5 Ki=2; accumulator starts at 0.
  localparam logic [52:0] VEC [12] = '{
    {4'd5, 2'd2, 1'b0, 2'd3, 12'h064, 32'd400},       // R5 acc=100
    {4'd5, 2'd2, 1'b0, 2'd3, 12'hFCE, 32'hFFFF_FF9C}, // R5 acc=50
    {4'd6, 2'd2, 1'b1, 2'd3, 12'h00A, 32'd120},       // R6 acc=70
    {4'd4, 2'd1, 1'b1, 2'd3, 12'h3E8, 32'd5070},      // R4 acc=70
    {4'd4, 2'd1, 1'b0, 2'd3, 12'hFF9, 32'd49},        // R4 acc=70
    {4'd7, 2'd2, 1'b0, 2'd0, 12'h830, 32'hFF00_0000}, // R7 acc=-1930
    {4'd7, 2'd1, 1'b0, 2'd2, 12'h000, 32'hFFFF_F800}, // R7
    {4'd7, 2'd1, 1'b0, 2'd1, 12'h000, 32'hFFFF_0000}, // R7
    {4'd3, 2'd0, 1'b0, 2'd3, 12'h1F4, 32'd0},         // R3 clears acc
    {4'd3, 2'd2, 1'b0, 2'd3, 12'h001, 32'd4},         // R3 acc was 0
    {4'd3, 2'd3, 1'b0, 2'd3, 12'h009, 32'd0},         // R3 reserved
    {4'd6, 2'd2, 1'b1, 2'd3, 12'hFFD, 32'hFFFF_FFEB}  // R6 acc=-6
  };

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: freq_word=%h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [1:0] m, input logic t,
                        input logic [1:0] w, input logic signed [11:0] e);
    @(negedge clk);
    loop_mode  = m;
    trk_sel    = t;
    width_code = w;
    err_in     = e;
    sym_stb    = 1'b1;
    @(negedge clk);
    sym_stb    = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", freq_word, 32'd0);

    for (int i = 0; i < 12; i++) begin
      strobe(VEC[i][48:47], VEC[i][46], VEC[i][45:44], VEC[i][43:32]);
      chk($sformatf("R%0d vector %0d", VEC[i][52:49], i), freq_word, VEC[i][31:0]);
    end

    // R2: inputs move without a strobe; nothing changes
    @(negedge clk);
    loop_mode = 2'd0; err_in = 12'sd700; width_code = 2'd0; trk_sel = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 hold between strobes", freq_word, 32'hFFFF_FFEB);
    strobe(2'd2, 1'b1, 2'd3, 12'sd0);
    chk("R2 captured at strobe", freq_word, 32'hFFFF_FFFA);

    // R8: drive accumulator to positive limit
    strobe(2'd0, 1'b0, 2'd3, 12'sd0);
    kp_acq = 12'sd0; ki_acq = 12'sd2047;
    for (int i = 0; i < 600; i++) strobe(2'd2, 1'b0, 2'd3, 12'sd2047);
    chk("R8 positive saturation", freq_word, 32'h7FFF_FFFF);

    // R9: large lead on top of a full accumulator
    kp_acq = 12'sd2047;
    strobe(2'd1, 1'b0, 2'd3, 12'sd2047);
    chk("R9 output saturation", freq_word, 32'h7FFF_FFFF);

    // R8: swing to the negative limit
    kp_acq = 12'sd0;
    for (int i = 0; i < 1100; i++) strobe(2'd2, 1'b0, 2'd3, -12'sd2048);
    chk("R8 negative saturation", freq_word, 32'h8000_0000);

    // R1: reset in mid operation clears the accumulator
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 output after reset", freq_word, 32'd0);
    kp_acq = 12'sd3;
    strobe(2'd1, 1'b0, 2'd3, 12'sd0);
    chk("R1 accumulator cleared", freq_word, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule